// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block tracks the shaft position of a two-channel incremental encoder. The two phase signals enter asynchronously, are resampled into the system clock domain, and then pass through a per-channel glitch filter whose length is set at run time. The cleaned levels are compared with their values one cycle earlier. Each change on one channel moves a position counter by one step. The step goes up or down depending on which channel changed and on the level of the other channel.

The counter wraps inside a software-chosen range from zero to a reload value. It emits a one-cycle pulse on each wrap, so a consumer can extend the position beyond the counter width. A consumer can also sample the count at a steady rate that is faster than the time the count takes to cross its full range. Two channels that change in the same cycle cannot be resolved into a direction. This is recorded in a sticky error flag and the count is left untouched. A level enable freezes counting without stopping the input sampling.

Top module: `qenc_counter`

## Requirements
- R1: Each valid change of either filtered channel moves the count by exactly one. A full quadrature cycle therefore gives four steps. No other cause changes the count.
- R2: Channel levels are written (A,B). The order 00, 10, 11, 01, 00 counts up and the reverse order counts down. A change on A counts up when the new A differs from B. A change on B counts up when the new B equals A. `dir_down` shows the direction of the last valid step: 0 means up, 1 means down.
- R3: Counting up from a count equal to `reload_val` gives 0, and `ovf_pulse` is high for exactly one cycle with that update.
- R4: Counting down from 0 gives `reload_val`, and `unf_pulse` is high for exactly one cycle with that update.
- R5: With filter setting N on `filt_len`, a channel level must be sampled N+1 times in a row before the filtered level follows it. A shorter excursion changes nothing.
- R6: With `filt_len` = 0, a level held for one clock period is counted. A channel that toggles once per clock is fully tracked.
- R7: When both filtered channels change in the same cycle, the count and direction stay unchanged and `step_err` goes high. It stays high until reset.
- R8: While `enable` is low the count holds, no wrap pulse fires and no error is recorded. Input activity during that time is not counted after `enable` returns high.
- R9: Reset (`rst_n` low) clears the count, `dir_down`, `step_err` and both pulses to 0.
- R10: Counting up from a count above `reload_val` also wraps to 0 with `ovf_pulse`. Counting down from such a count decrements it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling and state use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Counting enable, level sensitive |
| chan_a | input | 1 | Encoder phase A, asynchronous |
| chan_b | input | 1 | Encoder phase B, asynchronous |
| reload_val | input | CNT_W (16) | Upper limit of the count range |
| filt_len | input | FILT_W (4) | Filter setting N; N+1 equal samples needed |
| count | output | CNT_W (16) | Current position |
| dir_down | output | 1 | Direction of last valid step (1 = down) |
| ovf_pulse | output | 1 | One-cycle pulse on wrap from top to 0 |
| unf_pulse | output | 1 | One-cycle pulse on wrap from 0 to top |
| step_err | output | 1 | Sticky flag: both channels changed together |

## Verification
The bench targets the wrap points in both directions, including a reload value lowered below the current count. A design that compared only for equality would run through the full 16-bit range there instead of wrapping. It drives phases that change every clock, and a counter that missed single-cycle levels would fall short of four steps per cycle. It also sends glitches one sample shorter than the filter length and simultaneous changes of both channels. A wrong filter would count the glitch, and a naive decoder would step on the simultaneous change instead of flagging it. Random walks with random reload values and filter settings are compared with a bench model on final count, direction and the number of wrap pulses.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d    = pipe_q << 1;
    pipe_d[0] = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/qenc_filter.sv
module qenc_filter #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw,
  input  logic [FILT_W-1:0] setting,
  output logic              level
);
  localparam logic [FILT_W-1:0] RUN_ONE = 1;

  logic [FILT_W-1:0] run_q, run_d;
  logic              lvl_q, lvl_d;

  // Count samples that disagree with the held level; accept the new level
  // on the (setting+1)-th disagreeing sample in a row.
  always_comb begin
    run_d = run_q;
    lvl_d = lvl_q;
    if (raw == lvl_q) begin
      run_d = '0;
    end else if (run_q >= setting) begin
      lvl_d = raw;
      run_d = '0;
    end else begin
      run_d = run_q + RUN_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      run_q <= run_d;
      lvl_q <= lvl_d;
    end
  end

  assign level = lvl_q;
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fa,
  input  logic  fb,
  output step_e step
);
  logic prev_a, prev_b;
  logic chg_a, chg_b;

  assign chg_a = fa ^ prev_a;
  assign chg_b = fb ^ prev_b;

  always_comb begin
    case ({chg_a, chg_b})
      2'b10:   step = (fa != fb) ? STEP_UP : STEP_DOWN;
      2'b01:   step = (fb == fa) ? STEP_UP : STEP_DOWN;
      2'b11:   step = STEP_BAD;
      default: step = STEP_NONE;
    endcase
  end

  // History always tracks, so pausing the counter never leaves a stale edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a <= 1'b0;
      prev_b <= 1'b0;
    end else begin
      prev_a <= fa;
      prev_b <= fb;
    end
  end
endmodule

// File: rtl/qenc_count.sv
module qenc_count
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  step_e            step,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             ovf,
  output logic             unf,
  output logic             err
);
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;
  logic             ovf_q, ovf_d;
  logic             unf_q, unf_d;
  logic             err_q, err_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    ovf_d = 1'b0;
    unf_d = 1'b0;
    err_d = err_q;
    if (enable) begin
      case (step)
        STEP_UP: begin
          dir_d = 1'b0;
          if (cnt_q >= reload) begin
            cnt_d = '0;
            ovf_d = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_ONE;
          end
        end
        STEP_DOWN: begin
          dir_d = 1'b1;
          if (cnt_q == '0) begin
            cnt_d = reload;
            unf_d = 1'b1;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
        STEP_BAD: err_d = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
      err_q <= err_d;
    end
  end

  assign count    = cnt_q;
  assign dir_down = dir_q;
  assign ovf      = ovf_q;
  assign unf      = unf_q;
  assign err      = err_q;
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int FILT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             chan_a,
  input  logic             chan_b,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [FILT_W-1:0] filt_len,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             ovf_pulse,
  output logic             unf_pulse,
  output logic             step_err
);
  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0] raw_in;
  logic [NUM_CH-1:0] sync_lvl;
  logic [NUM_CH-1:0] filt_lvl;
  step_e             step;

  assign raw_in = {chan_b, chan_a};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    qenc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in[ch]),
      .q     (sync_lvl[ch])
    );
    qenc_filter #(.FILT_W(FILT_W)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (sync_lvl[ch]),
      .setting (filt_len),
      .level   (filt_lvl[ch])
    );
  end

  qenc_decode u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .fa    (filt_lvl[0]),
    .fb    (filt_lvl[1]),
    .step  (step)
  );

  qenc_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .step     (step),
    .reload   (reload_val),
    .count    (count),
    .dir_down (dir_down),
    .ovf      (ovf_pulse),
    .unf      (unf_pulse),
    .err      (step_err)
  );
endmodule

// File: rtl/qenc_counter_checker.sv
module qenc_counter_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [CNT_W-1:0] reload_val,
  input logic [CNT_W-1:0] count,
  input logic             dir_down,
  input logic             ovf_pulse,
  input logic             unf_pulse,
  input logic             step_err
);
  localparam logic [CNT_W-1:0] ONE = 1;

  assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |->
      (count == $past(count) + ONE || count == $past(count) - ONE || ovf_pulse || unf_pulse));

  assert_ovf_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> !dir_down);

  assert_unf_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    unf_pulse |-> dir_down);

  assert_ovf_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (count == '0));

  assert_unf_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unf_pulse |-> (count == $past(reload_val)));

  assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_pulse && unf_pulse));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_err |=> step_err);

  assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(count) && !ovf_pulse && !unf_pulse && $stable(dir_down)));
endmodule

bind qenc_counter qenc_counter_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .reload_val (reload_val),
  .count      (count),
  .dir_down   (dir_down),
  .ovf_pulse  (ovf_pulse),
  .unf_pulse  (unf_pulse),
  .step_err   (step_err)
);

// File: tb/qenc_counter_test.sv
`timescale 1ns/1ps
module qenc_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        chan_a = 1'b0;
  logic        chan_b = 1'b0;
  logic [15:0] reload_val = 16'd1000;
  logic [3:0]  filt_len = 4'd0;
  logic [15:0] count;
  logic        dir_down, ovf_pulse, unf_pulse, step_err;

  int errors = 0;
  int checks = 0;
  int ovf_seen = 0;
  int unf_seen = 0;
  int changes = 0;
  logic [15:0] last_count = 16'd0;
  int phase = 0;
  int model = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  qenc_counter uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .chan_a(chan_a), .chan_b(chan_b),
    .reload_val(reload_val), .filt_len(filt_len), .count(count), .dir_down(dir_down),
    .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse), .step_err(step_err)
  );

  // Monitor samples mid-high phase, away from both edges used elsewhere.
  always begin
    @(posedge clk);
    #2;
    if (rst_n) begin
      if (ovf_pulse) ovf_seen++;
      if (unf_pulse) unf_seen++;
      if (count != last_count) changes++;
    end
    last_count = count;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Gray order (A,B): 00,10,11,01
  task automatic drive_phase(input int p);
    chan_a = (p == 1 || p == 2);
    chan_b = (p == 2 || p == 3);
  endtask

  task automatic move(input bit up, input int hold);
    @(negedge clk);
    phase = up ? (phase + 1) % 4 : (phase + 3) % 4;
    drive_phase(phase);
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic settle();
    repeat (int'(filt_len) + 8) @(negedge clk);
  endtask

  function automatic int step_model(input int c, input bit up, input int rl,
                                    inout int ov, inout int un);
    if (up) begin
      if (c >= rl) begin ov++; return 0; end
      return c + 1;
    end
    if (c == 0) begin un++; return rl; end
    return c - 1;
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int ov0, un0, c0, eo, eu, d;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk("R9 count", int'(count), 0);
    chk("R9 dir", int'(dir_down), 0);
    chk("R9 err", int'(step_err), 0);
    chk("R9 pulses", int'(ovf_pulse | unf_pulse), 0);
    rst_n = 1'b1;
    enable = 1'b1;
    settle();

    // R1 / R2: two full cycles up, then three steps down
    for (int i = 0; i < 8; i++) move(1, 2);
    settle();
    chk("R1 count up", int'(count), 8);
    chk("R2 dir up", int'(dir_down), 0);
    for (int i = 0; i < 3; i++) move(0, 2);
    settle();
    chk("R2 count down", int'(count), 5);
    chk("R2 dir down", int'(dir_down), 1);

    // R6: one edge every clock
    for (int i = 0; i < 12; i++) move(1, 1);
    settle();
    chk("R6 fast tracking", int'(count), 17);

    // R3: wrap up at reload 20
    reload_val = 16'd20;
    ov0 = ovf_seen;
    for (int i = 0; i < 5; i++) move(1, 2);
    settle();
    chk("R3 wrap count", int'(count), 1);
    chk("R3 ovf pulses", ovf_seen - ov0, 1);

    // R4: wrap down
    un0 = unf_seen;
    for (int i = 0; i < 3; i++) move(0, 2);
    settle();
    chk("R4 wrap count", int'(count), 19);
    chk("R4 unf pulses", unf_seen - un0, 1);

    // R10: reload lowered below count
    reload_val = 16'd10;
    ov0 = ovf_seen;
    move(1, 2);
    settle();
    chk("R10 count", int'(count), 0);
    chk("R10 ovf", ovf_seen - ov0, 1);

    // R5: glitch of N samples ignored, N+1 accepted (N=5)
    reload_val = 16'd1000;
    filt_len = 4'd5;
    settle();
    c0 = changes;
    @(negedge clk);
    drive_phase((phase + 1) % 4);
    repeat (5) @(negedge clk);
    drive_phase(phase);
    settle();
    chk("R5 glitch ignored", changes - c0, 0);
    move(1, 6);
    settle();
    chk("R5 stable level counted", int'(count), 1);

    // R7: both channels at once
    filt_len = 4'd0;
    settle();
    @(negedge clk);
    phase = (phase + 2) % 4;
    drive_phase(phase);
    settle();
    chk("R7 count unchanged", int'(count), 1);
    chk("R7 err set", int'(step_err), 1);
    move(1, 2);
    settle();
    chk("R7 err sticky", int'(step_err), 1);
    chk("R7 counting resumes", int'(count), 2);

    // R8: disabled
    enable = 1'b0;
    reload_val = 16'd3;
    ov0 = ovf_seen;
    c0 = changes;
    for (int i = 0; i < 5; i++) move(1, 2);
    settle();
    chk("R8 held", changes - c0, 0);
    chk("R8 no pulse", ovf_seen - ov0, 0);
    enable = 1'b1;
    settle();
    chk("R8 no catch-up", int'(count), 2);
    move(1, 2);
    settle();
    chk("R8 resumes", int'(count), 3);

    // Random walks against the model
    model = int'(count);
    for (int r = 0; r < 4; r++) begin
      reload_val = 16'($urandom_range(60, 5));
      filt_len = 4'($urandom_range(3, 0));
      settle();
      ov0 = ovf_seen;
      un0 = unf_seen;
      eo = 0;
      eu = 0;
      d = 0;
      for (int i = 0; i < 300; i++) begin
        bit up;
        up = ($urandom_range(99, 0) < 60);
        move(up, int'(filt_len) + 1 + int'($urandom_range(2, 0)));
        model = step_model(model, up, int'(reload_val), eo, eu);
        d = up ? 0 : 1;
      end
      settle();
      chk("R1 random count", int'(count), model);
      chk("R2 random dir", int'(dir_down), d);
      chk("R3 random ovf", ovf_seen - ov0, eo);
      chk("R4 random unf", unf_seen - un0, eu);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule